// File: doc/BRIEF.md
# DMA interrupt aggregation and soft-reset unit

This block is the global control front end of a multi-channel DMA engine. Each channel reports the end of a block transfer as a one-cycle event pulse. The unit records every event as a pending bit in each of several interrupt groups. Each group has its own pending register and its own enable mask, and drives one level interrupt output. That output is high while any channel is both pending and enabled in that group. Software clears pending bits by writing ones to them. It can therefore write back a value it has just read and clear exactly the bits it saw.

The same register port also holds a soft-reset request. Once started, the unit wipes all pending and enable state. It holds that state cleared for a fixed number of cycles, then drops the request and raises a reset-done flag, which software polls. The register port uses word addresses and reads combinationally. Pending register of group n sits at address n. Enable mask of group n sits at address NLINES+n. Configuration sits at 2*NLINES, with the reset request at bit 1. Status sits at 2*NLINES+1, with reset-done at bit 0.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After hardware reset every pending, enable, configuration and status register reads 0 and all interrupt outputs are low.
- R2: An event pulse on channel c sets bit c in the pending register of every group.
- R3: A write to a pending register (address n) clears the bits written as 1 and leaves the other bits unchanged.
- R4: If an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: Enable mask n (address NLINES+n) reads back what was written. irq[n] is high exactly when pending n AND enable n is non-zero.
- R6: Clearing a channel's enable bit drops that channel's contribution to the group's interrupt. The pending bit is kept.
- R7: A write to the configuration register (address 2*NLINES) with bit 1 set starts a soft reset, and bit 1 reads 1 while it runs. Starting it clears all pending and enable registers. While it runs, events and writes to pending or enable registers are ignored and all interrupt outputs stay low.
- R8: Reset-done (status address bit 0) becomes 1 RST_CYCLES clock edges after the edge that accepted the request. In the same cycle, configuration bit 1 returns to 0.
- R9: Reset-done is cleared by a status write with bit 0 equal to 0, or by a new soft-reset request.
- R10: A read of an address above 2*NLINES+1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_evt | input | NCHAN | One-cycle end-of-block event per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address for read and write |
| reg_wdata | input | NCHAN | Write data |
| reg_rdata | output | NCHAN | Combinational read data for reg_addr |
| irq | output | NLINES | Level interrupt per group |

## Verification
The hardest situations to reach are the collisions. One is an event arriving in the same cycle as a clearing write to its bit. The other is events and register writes arriving while a soft reset is in progress. The bench creates the first with a vector that drives the pulse and the write in one cycle. It creates the second by driving an event and an enable write on the first edge after the request. It then polls the status bit on each following edge, so that both an early and a late reset-done are caught.

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NLINES     = 4,
  parameter int NCHAN      = 32,
  parameter int RST_CYCLES = 4,
  parameter int AW         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCHAN-1:0]  chan_evt,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [NCHAN-1:0]  reg_wdata,
  output logic [NCHAN-1:0]  reg_rdata,
  output logic [NLINES-1:0] irq
);
  localparam int CW       = $clog2(RST_CYCLES + 1);
  localparam int ADDR_CFG = 2 * NLINES;
  localparam int ADDR_STS = 2 * NLINES + 1;

  logic [NCHAN-1:0] pend [NLINES];
  logic [NCHAN-1:0] en   [NLINES];
  logic             busy, done;
  logic [CW-1:0]    cnt;

  wire start = reg_we && reg_addr == AW'(ADDR_CFG) && reg_wdata[1] && !busy;

  always_ff @(posedge clk) begin
    for (int l = 0; l < NLINES; l++) begin
      if (!rst_n || start || busy) begin
        pend[l] <= '0;
        en[l]   <= '0;
      end else begin
        pend[l] <= (pend[l] & ~((reg_we && reg_addr == AW'(l)) ? reg_wdata : '0)) | chan_evt;
        if (reg_we && reg_addr == AW'(NLINES + l)) en[l] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= CW'(RST_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else cnt <= cnt - 1'b1;
    end else if (reg_we && reg_addr == AW'(ADDR_STS) && !reg_wdata[0]) begin
      done <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int l = 0; l < NLINES; l++) begin
      if (reg_addr == AW'(l))          reg_rdata = pend[l];
      if (reg_addr == AW'(NLINES + l)) reg_rdata = en[l];
    end
    if (reg_addr == AW'(ADDR_CFG)) reg_rdata[1] = busy;
    if (reg_addr == AW'(ADDR_STS)) reg_rdata[0] = done;
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_irq
    assign irq[l] = |(pend[l] & en[l]);

    assert_evt_sets_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start && |chan_evt) |=> ((pend[l] & $past(chan_evt)) == $past(chan_evt)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(l) && !busy && !start)
        |=> ((pend[l] & $past(reg_wdata & ~chan_evt)) == '0));
  end

  assert_busy_masks_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> irq == '0);

  assert_busy_excludes_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] chan_evt = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_evt(chan_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {we, addr, wdata, evt, read addr, expected read, expected irq}
  localparam int NV = 9;
  localparam logic [108:0] VEC [NV] = '{
    {1'b1, 4'd4, 32'h0000_000F, 32'h0, 4'd4,  32'h0000_000F, 4'b0000}, // R5
    {1'b0, 4'd0, 32'h0,         32'h3, 4'd0,  32'h0000_0003, 4'b0001}, // R2 R5
    {1'b0, 4'd0, 32'h0,         32'h0, 4'd2,  32'h0000_0003, 4'b0001}, // R2
    {1'b1, 4'd0, 32'h0000_0001, 32'h0, 4'd0,  32'h0000_0002, 4'b0001}, // R3
    {1'b1, 4'd0, 32'h0000_0002, 32'h2, 4'd0,  32'h0000_0002, 4'b0001}, // R4
    {1'b1, 4'd4, 32'h0,         32'h0, 4'd0,  32'h0000_0002, 4'b0000}, // R6
    {1'b1, 4'd5, 32'h0000_0002, 32'h0, 4'd5,  32'h0000_0002, 4'b0010}, // R5
    {1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0, 4'd1,  32'h0,         4'b0000}, // R3
    {1'b0, 4'd0, 32'h0,         32'h0, 4'd12, 32'h0,         4'b0000}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [31:0] e);
    reg_we = we; reg_addr = a; reg_wdata = d; chan_evt = e;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; chan_evt = '0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 10; a++) rd("R1", 4'(a), 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][108], VEC[i][107:104], VEC[i][103:72], VEC[i][71:40]);
      rd("R2-vector", VEC[i][39:36], VEC[i][35:4]);
      chk("R5 irq vector", {28'h0, irq}, {28'h0, VEC[i][3:0]});
    end

    // soft reset during activity
    cycle(1'b1, 4'd7, 32'h1, 32'h1);
    chk("R5 irq3", {28'h0, irq}, 32'h8);
    cycle(1'b1, 4'd8, 32'h2, 32'h0);          // accepted edge E0
    rd("R7 cfg busy", 4'd8, 32'h2);
    chk("R7 irq low", {28'h0, irq}, 32'h0);
    rd("R7 pend cleared", 4'd3, 32'h0);
    cycle(1'b1, 4'd7, 32'hF, 32'h1);          // E1: ignored
    rd("R7 enable ignored", 4'd7, 32'h0);
    rd("R7 event ignored", 4'd3, 32'h0);
    rd("R8 not done E1", 4'd9, 32'h0);
    cycle(1'b0, 4'd0, 32'h0, 32'h0);          // E2
    rd("R8 not done E2", 4'd9, 32'h0);
    cycle(1'b0, 4'd0, 32'h0, 32'h0);          // E3
    rd("R8 not done E3", 4'd9, 32'h0);
    rd("R8 cfg still busy", 4'd8, 32'h2);
    cycle(1'b0, 4'd0, 32'h0, 32'h0);          // E4
    rd("R8 done", 4'd9, 32'h1);
    rd("R8 cfg cleared", 4'd8, 32'h0);

    cycle(1'b1, 4'd9, 32'h1, 32'h0);
    rd("R9 write 1 keeps done", 4'd9, 32'h1);
    cycle(1'b1, 4'd9, 32'h0, 32'h0);
    rd("R9 write 0 clears", 4'd9, 32'h0);

    cycle(1'b1, 4'd8, 32'h2, 32'h0);
    for (int k = 0; k < 4; k++) cycle(1'b0, 4'd0, 32'h0, 32'h0);
    rd("R8 second done", 4'd9, 32'h1);
    cycle(1'b1, 4'd8, 32'h2, 32'h0);
    rd("R9 request clears done", 4'd9, 32'h0);
    for (int k = 0; k < 4; k++) cycle(1'b0, 4'd0, 32'h0, 32'h0);

    cycle(1'b0, 4'd0, 32'h0, 32'h8000_0000);
    rd("R2 top channel", 4'd3, 32'h8000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule